// File: doc/BRIEF.md
# Load-Store Data Alignment Unit

This block sits between a processor's integer datapath and a data memory that is addressed by byte but is one word wide. On each memory request it adds a sign-extended 16-bit displacement to a base register value to form the effective address, and it checks that the access starts on a boundary that is a multiple of its size. For an aligned store it works out which byte lanes of the memory word must be written and places the source data in those lanes. For an aligned load it issues a read strobe. One cycle later it takes the returned memory word, picks out the addressed byte or halfword, and widens it to a full register with sign fill or zero fill.

Byte order is little endian: lane 0 carries bits 7:0 of the memory word and holds the byte whose address has low bits 00. The load side keeps the low address bits, the size and the extension mode of a load in registers while the memory answers. The extraction itself is combinational from the returned word and those registers. A misaligned or invalid request raises a flag and produces neither a write nor a read.

Top module: `lsu_align_unit`

## Requirements
- R1: `mem_addr` equals `base_val` plus `offset_imm` sign-extended to 32 bits, modulo 2^32, in the same cycle as the request.
- R2: Size codes are 00 byte, 01 halfword, 10 word and 11 invalid. An aligned byte store sets exactly one bit of `mem_be`: the bit at index `mem_addr[1:0]`, where bit 0 enables data bits 7:0. `mem_wdata` carries `store_src[7:0]` in all four lanes.
- R3: An aligned halfword store sets `mem_be` to 0011 when `mem_addr[1]` is 0 and to 1100 when it is 1. `mem_wdata` carries `store_src[15:0]` in both halves.
- R4: An aligned word store sets `mem_be` to 1111, and `mem_wdata` equals `store_src`. All four enables are never set unless `mem_addr[1:0]` is 00.
- R5: With `req_valid` high, `misalign` is raised for a halfword with `mem_addr[0]`=1, for a word with `mem_addr[1:0]`≠00, and for size code 11. While it is raised, `mem_be` is 0000 and `mem_rd` is low. Byte accesses never raise it.
- R6: An aligned load asserts `mem_rd` in its request cycle. `load_valid` is high in the next cycle and only then, and the memory returns the word on `rsp_rdata` during that next cycle.
- R7: A byte load returns the byte in lane `mem_addr[1:0]` of the returned word. It is sign-extended when `req_unsigned` is 0 and zero-extended when `req_unsigned` is 1.
- R8: A halfword load returns bits 15:0 of the returned word when `mem_addr[1]` is 0 and bits 31:16 when it is 1. It is extended as in R7.
- R9: A word load returns the returned word unchanged.
- R10: With `req_valid` low, `mem_be` is 0000 and `mem_rd` and `misalign` are low. After reset `load_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A memory request is present this cycle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| req_unsigned | input | 1 | Load extension: 1 zero fill, 0 sign fill |
| base_val | input | 32 | Base register value |
| offset_imm | input | 16 | Signed displacement |
| store_src | input | 32 | Source register for stores |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rd | output | 1 | Read strobe for an aligned load |
| misalign | output | 1 | Request is misaligned or has an invalid size |
| rsp_rdata | input | 32 | Word returned by memory one cycle after `mem_rd` |
| load_result | output | 32 | Extracted and extended load value |
| load_valid | output | 1 | `load_result` is meaningful this cycle |

## Verification
The assertions assume that after reset every request input holds a defined 0 or 1 value in every cycle. The enable-shape and quiet-on-misalign properties would be vacuous or misleading on unknown sizes or addresses. They also assume `rsp_rdata` is valid in the cycle after `mem_rd`, because the unsigned-byte zero-fill property looks at `load_result` in that cycle. The bench drives every input to a known value from time zero, including idle cycles and the data bus. It changes the inputs just after the rising edge and supplies the word for a load in exactly the following cycle, as a memory with one cycle of read latency would.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

   localparam int unsigned LANE_BITS = 8;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_BAD  = 2'b11
   } acc_size_e;

   function automatic int unsigned lanes_of(input int unsigned data_w);
      return data_w / LANE_BITS;
   endfunction

endpackage

// File: rtl/lsu_ea_adder.sv
module lsu_ea_adder #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFFS_W = 16
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFFS_W-1:0] offs_i,
   output logic [ADDR_W-1:0] ea_o
);
   localparam int unsigned EXT_W = ADDR_W - OFFS_W;

   if (OFFS_W == 0 || OFFS_W >= ADDR_W) begin : g_bad_offs
      $error("lsu_ea_adder: OFFS_W must be nonzero and narrower than ADDR_W");
   end

   logic [ADDR_W-1:0] offs_ext;

   assign offs_ext = {{EXT_W{offs_i[OFFS_W-1]}}, offs_i};
   assign ea_o     = base_i + offs_ext;
endmodule

// File: rtl/lsu_align_check.sv
module lsu_align_check
   import lsu_align_pkg::*;
#(
   parameter int unsigned LW = 2
) (
   input  logic [LW-1:0] addr_lo_i,
   input  acc_size_e     size_i,
   output logic          bad_o
);
   if (LW < 2) begin : g_bad_lw
      $error("lsu_align_check: at least two address bits are needed");
   end

   always_comb begin
      unique case (size_i)
         SZ_BYTE: bad_o = 1'b0;
         SZ_HALF: bad_o = addr_lo_i[0];
         SZ_WORD: bad_o = |addr_lo_i;
         default: bad_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
   import lsu_align_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                              active_i,
   input  logic [$clog2(DATA_W/8)-1:0]       addr_lo_i,
   input  acc_size_e                         size_i,
   input  logic [DATA_W-1:0]                 src_i,
   output logic [DATA_W/8-1:0]               be_o,
   output logic [DATA_W-1:0]                 wdata_o
);
   localparam int unsigned LANES = DATA_W / LANE_BITS;
   localparam int unsigned LW    = $clog2(LANES);

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic       hit;
      logic [7:0] lane_byte;

      always_comb begin
         unique case (size_i)
            SZ_BYTE: begin
               hit       = (addr_lo_i == LW'(j));
               lane_byte = src_i[7:0];
            end
            SZ_HALF: begin
               hit       = (addr_lo_i[LW-1:1] == (LW-1)'(j / 2));
               lane_byte = src_i[8*(j%2) +: 8];
            end
            default: begin
               hit       = 1'b1;
               lane_byte = src_i[8*j +: 8];
            end
         endcase
      end

      assign be_o[j]          = active_i & hit;
      assign wdata_o[8*j +: 8] = lane_byte;
   end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_align_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]            rdata_i,
   input  logic [$clog2(DATA_W/8)-1:0]  lane_i,
   input  acc_size_e                    size_i,
   input  logic                         zero_fill_i,
   output logic [DATA_W-1:0]            result_o
);
   localparam int unsigned HW = 2 * LANE_BITS;

   logic [LANE_BITS-1:0] byte_sel;
   logic [HW-1:0]        half_sel;
   logic                 byte_fill;
   logic                 half_fill;

   assign byte_sel  = rdata_i[LANE_BITS*int'(lane_i) +: LANE_BITS];
   assign half_sel  = rdata_i[HW*int'(lane_i >> 1) +: HW];
   assign byte_fill = ~zero_fill_i & byte_sel[LANE_BITS-1];
   assign half_fill = ~zero_fill_i & half_sel[HW-1];

   always_comb begin
      unique case (size_i)
         SZ_BYTE: result_o = {{(DATA_W-LANE_BITS){byte_fill}}, byte_sel};
         SZ_HALF: result_o = {{(DATA_W-HW){half_fill}}, half_sel};
         default: result_o = rdata_i;
      endcase
   end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
   import lsu_align_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned OFFS_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_store,
   input  logic [1:0]           req_size,
   input  logic                 req_unsigned,
   input  logic [ADDR_W-1:0]    base_val,
   input  logic [OFFS_W-1:0]    offset_imm,
   input  logic [DATA_W-1:0]    store_src,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [DATA_W/8-1:0]  mem_be,
   output logic [DATA_W-1:0]    mem_wdata,
   output logic                 mem_rd,
   output logic                 misalign,
   input  logic [DATA_W-1:0]    rsp_rdata,
   output logic [DATA_W-1:0]    load_result,
   output logic                 load_valid
);
   localparam int unsigned LANES = lanes_of(DATA_W);
   localparam int unsigned LW    = $clog2(LANES);

   if (DATA_W < 32 || (DATA_W % LANE_BITS) != 0 || (LANES & (LANES - 1)) != 0) begin : g_bad_data
      $error("lsu_align_unit: DATA_W must be a power-of-two count of bytes, at least 32 bits");
   end
   if (ADDR_W < LW + 1) begin : g_bad_addr
      $error("lsu_align_unit: ADDR_W too narrow for the lane index");
   end

   acc_size_e   size_q_in;
   logic        bad_align;
   logic        store_go;
   logic [LW-1:0] lat_lane;
   acc_size_e   lat_size;
   logic        lat_zero;

   assign size_q_in = acc_size_e'(req_size);

   lsu_ea_adder #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_ea (
      .base_i (base_val),
      .offs_i (offset_imm),
      .ea_o   (mem_addr)
   );

   lsu_align_check #(.LW(LW)) u_chk (
      .addr_lo_i (mem_addr[LW-1:0]),
      .size_i    (size_q_in),
      .bad_o     (bad_align)
   );

   assign misalign = req_valid & bad_align;
   assign store_go = req_valid & req_store & ~bad_align;
   assign mem_rd   = req_valid & ~req_store & ~bad_align;

   lsu_store_steer #(.DATA_W(DATA_W)) u_st (
      .active_i  (store_go),
      .addr_lo_i (mem_addr[LW-1:0]),
      .size_i    (size_q_in),
      .src_i     (store_src),
      .be_o      (mem_be),
      .wdata_o   (mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_valid <= 1'b0;
         lat_lane   <= '0;
         lat_size   <= SZ_WORD;
         lat_zero   <= 1'b0;
      end else begin
         load_valid <= mem_rd;
         if (mem_rd) begin
            lat_lane <= mem_addr[LW-1:0];
            lat_size <= size_q_in;
            lat_zero <= req_unsigned;
         end
      end
   end

   lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
      .rdata_i     (rsp_rdata),
      .lane_i      (lat_lane),
      .size_i      (lat_size),
      .zero_fill_i (lat_zero),
      .result_o    (load_result)
   );

   // R5
   misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (mem_be == '0 && !mem_rd));

   // R4
   full_be_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_be == '1) |-> (mem_addr[LW-1:0] == '0));

   // R2
   be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(mem_be) == 0 || $countones(mem_be) == 1 ||
       $countones(mem_be) == 2 || $countones(mem_be) == LANES));

   // R6
   rd_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> load_valid);

   // R6
   no_rd_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rd |=> !load_valid);

   // R7
   ubyte_zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_valid && lat_size == SZ_BYTE && lat_zero) |-> (load_result[DATA_W-1:8] == '0));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (mem_be == '0 && !mem_rd && !misalign));
endmodule

// File: tb/lsu_align_unit_test.sv
`timescale 1ns/1ps
module lsu_align_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic        req_unsigned = 1'b0;
   logic [31:0] base_val = '0;
   logic [15:0] offset_imm = '0;
   logic [31:0] store_src = '0;
   logic [31:0] rsp_rdata = '0;
   logic [31:0] mem_addr, mem_wdata, load_result;
   logic [3:0]  mem_be;
   logic        mem_rd, misalign, load_valid;

   always #10 clk = ~clk;

   lsu_align_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_size(req_size), .req_unsigned(req_unsigned), .base_val(base_val),
      .offset_imm(offset_imm), .store_src(store_src), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .misalign(misalign),
      .rsp_rdata(rsp_rdata), .load_result(load_result), .load_valid(load_valid)
   );

   typedef struct {
      string       tag;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic        chk_wdata;
      logic        rd;
      logic        mis;
      logic        lv;
   } req_item_t;

   typedef struct {
      string       tag;
      logic [31:0] value;
   } ld_item_t;

   req_item_t req_q[$];
   ld_item_t  ld_q[$];
   int compared = 0;
   int mismatched = 0;
   bit mon_on = 0;
   bit prev_rd = 0;
   logic [31:0] pending_word = '0;

   task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   task automatic drive(input bit v, input bit st, input logic [1:0] sz, input bit uns,
                        input logic [31:0] base, input logic [15:0] off,
                        input logic [31:0] src, input logic [31:0] word, input string tag);
      req_item_t it;
      logic [31:0] ea;
      bit mis;
      logic [31:0] sel;
      @(posedge clk);
      #1;
      req_valid = v; req_store = st; req_size = sz; req_unsigned = uns;
      base_val = base; offset_imm = off; store_src = src;
      rsp_rdata = pending_word;
      ea  = base + {{16{off[15]}}, off};
      mis = v && (sz == 2'b11 || (sz == 2'b01 && ea[0]) || (sz == 2'b10 && ea[1:0] != 2'b00));
      it.tag = tag; it.addr = ea; it.mis = mis; it.lv = prev_rd;
      it.rd = v && !st && !mis;
      it.be = 4'b0000; it.wdata = '0; it.chk_wdata = 1'b0;
      if (v && st && !mis) begin
         it.chk_wdata = 1'b1;
         case (sz)
            2'b00: begin it.be = 4'b0001 << ea[1:0]; it.wdata = {4{src[7:0]}}; end
            2'b01: begin it.be = ea[1] ? 4'b1100 : 4'b0011; it.wdata = {2{src[15:0]}}; end
            default: begin it.be = 4'b1111; it.wdata = src; end
         endcase
      end
      req_q.push_back(it);
      prev_rd = it.rd;
      if (it.rd) begin
         ld_item_t li;
         pending_word = word;
         case (sz)
            2'b00: begin
               sel = word >> (8 * ea[1:0]);
               li.value = uns ? {24'h0, sel[7:0]} : {{24{sel[7]}}, sel[7:0]};
            end
            2'b01: begin
               sel = ea[1] ? {16'h0, word[31:16]} : {16'h0, word[15:0]};
               li.value = uns ? {16'h0, sel[15:0]} : {{16{sel[15]}}, sel[15:0]};
            end
            default: li.value = word;
         endcase
         li.tag = tag;
         ld_q.push_back(li);
      end else begin
         pending_word = 32'hDEAD_BEEF;
      end
   endtask

   // monitor: compares the request outputs and the load results
   always @(negedge clk) begin
      if (mon_on && req_q.size() > 0) begin
         req_item_t it;
         it = req_q.pop_front();
         cmp(it.tag, "mem_addr (R1)", mem_addr, it.addr);
         cmp(it.tag, "mem_be", {28'h0, mem_be}, {28'h0, it.be});
         if (it.chk_wdata) cmp(it.tag, "mem_wdata", mem_wdata, it.wdata);
         cmp(it.tag, "mem_rd", {31'h0, mem_rd}, {31'h0, it.rd});
         cmp(it.tag, "misalign (R5)", {31'h0, misalign}, {31'h0, it.mis});
         cmp(it.tag, "load_valid (R6)", {31'h0, load_valid}, {31'h0, it.lv});
         if (load_valid) begin
            if (ld_q.size() == 0) begin
               cmp("R6", "unexpected load", 32'h1, 32'h0);
            end else begin
               ld_item_t li;
               li = ld_q.pop_front();
               cmp(li.tag, "load_result", load_result, li.value);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      cmp("R10", "load_valid in reset", {31'h0, load_valid}, 32'h0);
      cmp("R10", "mem_be in reset", {28'h0, mem_be}, 32'h0);
      cmp("R10", "mem_rd in reset", {31'h0, mem_rd}, 32'h0);
      @(posedge clk); #1 rst_n = 1'b1;
      mon_on = 1;

      // R1 address arithmetic, including negative offset and wrap
      drive(1, 1, 2'b00, 0, 32'h0000_0010, 16'hFFF0, 32'h0, 32'h0, "R1");
      drive(1, 1, 2'b00, 0, 32'hFFFF_FFFC, 16'h0008, 32'h0, 32'h0, "R1");
      drive(1, 1, 2'b10, 0, 32'h1234_0000, 16'h7FFC, 32'hCAFE_F00D, 32'h0, "R1");

      // R2 byte stores on every lane
      for (int k = 0; k < 4; k++)
         drive(1, 1, 2'b00, 0, 32'h0000_1000 + k, 16'h0000, 32'h1122_33A5 + k, 32'h0, "R2");

      // R3 halfword stores, both halves
      drive(1, 1, 2'b01, 0, 32'h0000_2000, 16'h0000, 32'hFFFF_BEEF, 32'h0, "R3");
      drive(1, 1, 2'b01, 0, 32'h0000_2000, 16'h0002, 32'h0000_1234, 32'h0, "R3");

      // R4 word store
      drive(1, 1, 2'b10, 0, 32'h0000_3000, 16'h0004, 32'h89AB_CDEF, 32'h0, "R4");

      // R5 misaligned and invalid requests, loads and stores
      drive(1, 1, 2'b01, 0, 32'h0000_4001, 16'h0000, 32'h1111_1111, 32'h0, "R5");
      drive(1, 1, 2'b10, 0, 32'h0000_4002, 16'h0000, 32'h2222_2222, 32'h0, "R5");
      drive(1, 0, 2'b10, 0, 32'h0000_4003, 16'h0000, 32'h0, 32'h0, "R5");
      drive(1, 0, 2'b01, 1, 32'h0000_4003, 16'h0000, 32'h0, 32'h0, "R5");
      drive(1, 1, 2'b11, 0, 32'h0000_4000, 16'h0000, 32'h3333_3333, 32'h0, "R5");

      // R10 idle cycle with otherwise store-like inputs
      drive(0, 1, 2'b10, 0, 32'h0000_5000, 16'h0000, 32'h4444_4444, 32'h0, "R10");

      // R7 byte loads on every lane, signed and unsigned
      for (int k = 0; k < 4; k++) begin
         drive(1, 0, 2'b00, 0, 32'h0000_6000 + k, 16'h0000, 32'h0, 32'h80F1_7F92, "R7");
         drive(1, 0, 2'b00, 1, 32'h0000_6000 + k, 16'h0000, 32'h0, 32'h80F1_7F92, "R7");
      end

      // R8 halfword loads, both halves, both extensions
      drive(1, 0, 2'b01, 0, 32'h0000_7000, 16'h0000, 32'h0, 32'h7ABC_8123, "R8");
      drive(1, 0, 2'b01, 1, 32'h0000_7000, 16'h0000, 32'h0, 32'h7ABC_8123, "R8");
      drive(1, 0, 2'b01, 0, 32'h0000_7000, 16'h0002, 32'h0, 32'h9ABC_0123, "R8");
      drive(1, 0, 2'b01, 1, 32'h0000_7002, 16'h0000, 32'h0, 32'h9ABC_0123, "R8");

      // R9 word loads, back to back and after a gap
      drive(1, 0, 2'b10, 0, 32'h0000_8000, 16'h0000, 32'h0, 32'hF00D_CAFE, "R9");
      drive(1, 0, 2'b10, 1, 32'h0000_8004, 16'hFFFC, 32'h0, 32'h0123_4567, "R9");
      drive(0, 0, 2'b10, 0, 32'h0, 16'h0, 32'h0, 32'h0, "R6");
      drive(1, 0, 2'b10, 0, 32'h0000_8008, 16'h0000, 32'h0, 32'h8000_0001, "R9");

      // R6 a store right after a load still delivers the load result
      drive(1, 0, 2'b00, 0, 32'h0000_9003, 16'h0000, 32'h0, 32'hC000_0000, "R6");
      drive(1, 1, 2'b00, 0, 32'h0000_9000, 16'h0000, 32'h0000_0055, 32'h0, "R6");

      repeat (3) drive(0, 0, 2'b00, 0, 32'h0, 16'h0, 32'h0, 32'h0, "R10");
      @(posedge clk); @(negedge clk); #1;
      if (ld_q.size() != 0) cmp("R6", "undelivered loads", ld_q.size(), 32'h0);
      summary();
      $finish;
   end
endmodule